// File: doc/BRIEF.md
# Streaming Reed-Solomon (255,239) Parity Encoder

This block is a systematic Reed-Solomon encoder over GF(2^8). It is built with field polynomial x^8+x^4+x^3+x^2+1 (0x11D) and primitive element 0x02. The check polynomial is the product of (x + α^i) for i = 0 to 15. Information bytes enter one per clock through a valid/ready handshake. Each byte is copied unchanged to the output one cycle later and is folded into a 16-symbol remainder register as it passes. Once the 239th information byte of a codeword has been accepted, the block emits the 16 check bytes on the same output in the following 16 cycles. Each codeword is therefore 255 bytes long.

The controller has two named states. In `ST_FILL` the block is ready and absorbs information bytes. Positions 0 to 238 are counted, and a cycle with `in_valid` low holds everything. The transition `ST_FILL -> ST_DRAIN` is taken when the byte at position 238 is accepted. In `ST_DRAIN` the ready output is low, and the remainder register shifts out with zero feedback, highest-order symbol first. The transition `ST_DRAIN -> ST_FILL` is taken on the 255th output byte. At that point the register is cleared and `out_last` is raised.

A byte accepted with `in_start` high always begins a new codeword at position 0. Any partial remainder is discarded. A synchronous, active-high reset returns the block to `ST_FILL` at position 0.

Top module: `rs_parity_encoder`

## Requirements
- R1: Every accepted information byte (a cycle with `in_valid` and `in_ready` high) appears on `out_data` in the next cycle, unchanged, with `out_valid` high.
- R2: The 16 check bytes follow the 239th information byte in 16 consecutive cycles. Read with the first output byte as the coefficient of x^254, the 255 output bytes form a polynomial that is zero at α^0 through α^15, where α = 0x02 in GF(2^8) with polynomial 0x11D.
- R3: `in_ready` is low in exactly the 16 cycles that produce the check bytes, and it is high at every other time outside reset. `in_valid`, `in_start` and `in_data` are ignored while `in_ready` is low.
- R4: Cycles with `in_valid` low change neither the remainder nor the byte position. Any pattern of idle cycles yields the same codeword as gapless input.
- R5: A byte accepted with `in_start` high is taken as position 0 of a fresh codeword, and the remainder of any unfinished codeword is discarded.
- R6: `out_last` is high only together with the 255th output byte of a codeword, and it is never high without `out_valid`.
- R7: While `rst` is high at a rising edge, the next cycle shows `out_valid` low, `out_last` low and `in_ready` high. A codeword interrupted by reset leaves no trace in the next one.
- R8: A codeword whose information bytes are all 0x00 gets 16 check bytes of 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Information byte present on `in_data` |
| in_start | input | 1 | Marks the byte as the first of a new codeword |
| in_data | input | 8 | Information byte |
| in_ready | output | 1 | High while information bytes are accepted |
| out_valid | output | 1 | `out_data` carries a codeword byte |
| out_data | output | 8 | Forwarded information byte or check byte |
| out_last | output | 1 | Marks the final check byte of a codeword |

## Verification
Two things can fall in the same cycle. The acceptance of the last information byte feeds the remainder at the edge where the controller switches to draining. The first check byte then leaves on the very next cycle, with no gap after the forwarded data. The bench provokes this pairing under gapless input, alternating gaps and irregular gaps, and with `in_valid` and `in_start` held high through the whole drain window. It judges the result by requiring exactly 255 contiguous tail bytes, all 16 syndromes equal to zero, and exactly 16 cycles with ready low. The other collisions are an `in_start` arriving mid-codeword and a reset arriving mid-drain; each is followed by a full codeword that must verify.

// File: rtl/rs_enc_pkg.sv
package rs_enc_pkg;

    localparam int             SYM_W      = 8;
    localparam logic [SYM_W:0] FIELD_POLY = 9'h11D;
    localparam logic [SYM_W-1:0] PRIM_ELEM = 8'h02;

    typedef logic [SYM_W-1:0] sym_t;

    typedef enum logic [0:0] {
        ST_FILL  = 1'b0,
        ST_DRAIN = 1'b1
    } enc_state_e;

    // Carry-less product followed by reduction modulo FIELD_POLY
    function automatic sym_t gf_mul(input sym_t a, input sym_t b);
        logic [2*SYM_W-2:0] prod;
        logic [2*SYM_W-2:0] red;
        prod = '0;
        for (int i = 0; i < SYM_W; i++) begin
            if (b[i]) prod = prod ^ ((2*SYM_W-1)'(a) << i);
        end
        for (int k = 2*SYM_W-2; k >= SYM_W; k--) begin
            red = (2*SYM_W-1)'(FIELD_POLY) << (k - SYM_W);
            if (prod[k]) prod = prod ^ red;
        end
        return prod[SYM_W-1:0];
    endfunction

endpackage

// File: rtl/rs_const_mul.sv
module rs_const_mul
    import rs_enc_pkg::*;
#(
    parameter logic [SYM_W-1:0] COEF = 8'h01
) (
    input  logic [SYM_W-1:0] din,
    output logic [SYM_W-1:0] dout
);

    always_comb begin
        dout = gf_mul(din, COEF);
    end

endmodule

// File: rtl/rs_remainder_lfsr.sv
module rs_remainder_lfsr
    import rs_enc_pkg::*;
#(
    parameter int NPAR = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             absorb,
    input  logic             restart,
    input  logic             drain,
    input  logic             clear,
    input  logic [SYM_W-1:0] din,
    output logic [SYM_W-1:0] top_sym
);

    // Coefficients g0..g(NPAR-1) of the monic product of (x + alpha^i)
    function automatic logic [NPAR-1:0][SYM_W-1:0] calc_gen();
        logic [NPAR:0][SYM_W-1:0] g;
        logic [SYM_W-1:0]         root;
        g    = '0;
        g[0] = SYM_W'(1);
        root = SYM_W'(1);
        for (int i = 0; i < NPAR; i++) begin
            for (int k = NPAR; k > 0; k--) begin
                if (k <= i + 1) g[k] = g[k-1] ^ gf_mul(g[k], root);
            end
            g[0] = gf_mul(g[0], root);
            root = gf_mul(root, PRIM_ELEM);
        end
        return g[NPAR-1:0];
    endfunction

    localparam logic [NPAR-1:0][SYM_W-1:0] GEN = calc_gen();

    logic [NPAR-1:0][SYM_W-1:0] rem_q;
    logic [NPAR-1:0][SYM_W-1:0] base;
    logic [NPAR-1:0][SYM_W-1:0] prod;
    logic [NPAR-1:0][SYM_W-1:0] rem_d;
    logic [SYM_W-1:0]           fb;

    always_comb begin
        base = restart ? '0 : rem_q;
        fb   = drain ? '0 : (din ^ base[NPAR-1]);
    end

    for (genvar s = 0; s < NPAR; s++) begin : g_tap
        rs_const_mul #(.COEF(GEN[s])) u_mul (
            .din  (fb),
            .dout (prod[s])
        );
        if (s == 0) begin : g_first
            assign rem_d[s] = prod[s];
        end else begin : g_rest
            assign rem_d[s] = base[s-1] ^ prod[s];
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            rem_q <= '0;
        end else if (absorb || drain) begin
            rem_q <= rem_d;
        end
    end

    assign top_sym = rem_q[NPAR-1];

    // R4
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !absorb && !drain && !clear |=> $stable(rem_q));

    // R2
    empty_after_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clear |=> (rem_q == '0));

endmodule

// File: rtl/rs_enc_ctrl.sv
module rs_enc_ctrl
    import rs_enc_pkg::*;
#(
    parameter int DATA_LEN = 239,
    parameter int NPAR     = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  logic in_start,
    output logic in_ready,
    output logic absorb,
    output logic restart,
    output logic drain,
    output logic clear,
    output logic emit_last
);

    localparam int TOTAL = DATA_LEN + NPAR;
    localparam int POS_W = $clog2(TOTAL);
    localparam logic [POS_W-1:0] LAST_DATA = POS_W'(DATA_LEN - 1);
    localparam logic [POS_W-1:0] LAST_POS  = POS_W'(TOTAL - 1);

    enc_state_e       state_q, state_d;
    logic [POS_W-1:0] pos_q, pos_d;
    logic [POS_W-1:0] eff_pos;
    logic             take;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_FILL;
            pos_q   <= '0;
        end else begin
            state_q <= state_d;
            pos_q   <= pos_d;
        end
    end

    always_comb begin
        take    = in_valid && (state_q == ST_FILL);
        eff_pos = in_start ? '0 : pos_q;
        state_d = state_q;
        pos_d   = pos_q;
        unique case (state_q)
            ST_FILL: begin
                if (take) begin
                    if (eff_pos == LAST_DATA) begin
                        state_d = ST_DRAIN;
                    end
                    pos_d = eff_pos + 1'b1;
                end
            end
            ST_DRAIN: begin
                if (pos_q == LAST_POS) begin
                    state_d = ST_FILL;
                    pos_d   = '0;
                end else begin
                    pos_d = pos_q + 1'b1;
                end
            end
            default: begin
                state_d = ST_FILL;
                pos_d   = '0;
            end
        endcase
    end

    always_comb begin
        in_ready  = 1'b0;
        absorb    = 1'b0;
        restart   = 1'b0;
        drain     = 1'b0;
        clear     = 1'b0;
        emit_last = 1'b0;
        unique case (state_q)
            ST_FILL: begin
                in_ready = 1'b1;
                absorb   = take;
                restart  = take && in_start;
            end
            ST_DRAIN: begin
                drain     = 1'b1;
                clear     = (pos_q == LAST_POS);
                emit_last = (pos_q == LAST_POS);
            end
            default: ;
        endcase
    end

    // R2
    pos_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        pos_q <= LAST_POS);

    // R5
    start_rewinds_chk: assert property (@(posedge clk) disable iff (rst)
        take && in_start |=> (pos_q == POS_W'(1)) || (state_q == ST_DRAIN));

    // R3
    drain_length_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DRAIN) |-> (pos_q >= POS_W'(DATA_LEN)));

endmodule

// File: rtl/rs_parity_encoder.sv
module rs_parity_encoder
    import rs_enc_pkg::*;
#(
    parameter int DATA_LEN = 239,
    parameter int NPAR     = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_start,
    input  logic [SYM_W-1:0] in_data,
    output logic             in_ready,
    output logic             out_valid,
    output logic [SYM_W-1:0] out_data,
    output logic             out_last
);

    logic             absorb;
    logic             restart;
    logic             drain;
    logic             clear;
    logic             emit_last;
    logic [SYM_W-1:0] top_sym;

    rs_enc_ctrl #(.DATA_LEN(DATA_LEN), .NPAR(NPAR)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_start  (in_start),
        .in_ready  (in_ready),
        .absorb    (absorb),
        .restart   (restart),
        .drain     (drain),
        .clear     (clear),
        .emit_last (emit_last)
    );

    rs_remainder_lfsr #(.NPAR(NPAR)) u_lfsr (
        .clk     (clk),
        .rst     (rst),
        .absorb  (absorb),
        .restart (restart),
        .drain   (drain),
        .clear   (clear),
        .din     (in_data),
        .top_sym (top_sym)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_last  <= 1'b0;
        end else begin
            out_valid <= absorb || drain;
            out_data  <= drain ? top_sym : in_data;
            out_last  <= emit_last;
        end
    end

    // R1
    forward_next_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready |=> out_valid && (out_data == $past(in_data)));

    // R6
    last_has_valid_chk: assert property (@(posedge clk) disable iff (rst)
        out_last |-> out_valid);

    // R3
    drain_emits_chk: assert property (@(posedge clk) disable iff (rst)
        !in_ready |=> out_valid);

    // R3
    unsolicited_only_in_drain_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && !$past(in_valid && in_ready) |-> $past(!in_ready));

endmodule

// File: tb/rs_parity_encoder_bench.sv
module rs_parity_encoder_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NDATA      = 239;
    localparam int NTOT       = 255;

    // entry: [31] drive garbage during drain, [25:24] gap mode, [23:0] seed
    // gap mode 0 none, 1 alternate idle, 2 irregular idle, 3 all-zero data
    localparam logic [31:0] STIM [5] = '{
        32'h0000_0001,
        32'h0100_004D,
        32'h0200_04D2,
        32'h0300_0000,
        32'h8200_03E7
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic       in_start = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_ready;
    logic       out_valid;
    logic [7:0] out_data;
    logic       out_last;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [7:0] sent [NDATA];
    logic [7:0] rec  [300];
    logic       rlast[300];
    int         rcnt;
    int         lat_err;
    int         nrdy;

    always #(CLK_PERIOD/2) clk = ~clk;

    rs_parity_encoder u_rs_parity_encoder (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_start  (in_start),
        .in_data   (in_data),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_last  (out_last)
    );

    function automatic logic [7:0] fmul(logic [7:0] a, logic [7:0] b);
        logic [7:0] p = 8'h00;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) p ^= a;
            a = a[7] ? ((a << 1) ^ 8'h1D) : (a << 1);
        end
        return p;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        bit         acc;
        logic [7:0] d;
        acc = in_valid && in_ready;
        d   = in_data;
        if (!in_ready && !rst) nrdy++;
        @(negedge clk);
        if (acc && !(out_valid && out_data == d)) lat_err++;
        if (out_valid && rcnt < 300) begin
            rec[rcnt]   = out_data;
            rlast[rcnt] = out_last;
            rcnt++;
        end
    endtask

    task automatic send(input logic [31:0] entry, input int ndata,
                        input int ntail, input bit eval);
        logic [31:0] x;
        int          mode;
        bit          garb;
        int          idle;
        int          bad;
        logic [7:0]  s;
        logic [7:0]  root;
        x    = {8'h5A, entry[23:0]} ^ 32'h1234_5678;
        mode = int'(entry[25:24]);
        garb = entry[31];
        rcnt = 0; lat_err = 0; nrdy = 0;
        for (int n = 0; n < ndata; n++) begin
            x = x * 32'd1103515245 + 32'd12345;
            idle = (mode == 1) ? 1 : (mode == 2) ? int'(x[9:8]) % 3 : 0;
            for (int k = 0; k < idle; k++) begin
                in_valid = 1'b0; in_start = 1'b0; in_data = x[7:0];
                tick();
            end
            in_valid = 1'b1;
            in_start = (n == 0);
            in_data  = (mode == 3) ? 8'h00 : x[23:16];
            sent[n]  = in_data;
            tick();
        end
        for (int k = 0; k < ntail; k++) begin
            in_valid = garb && (k < 16);
            in_start = garb && (k < 16);
            in_data  = 8'hA5;
            tick();
        end
        in_valid = 1'b0; in_start = 1'b0;
        if (eval) begin
            chk(rcnt == NTOT, "R2 codeword length", rcnt, NTOT);
            bad = 0;
            for (int n = 0; n < NDATA; n++) if (rec[n] !== sent[n]) bad++;
            chk(bad == 0, "R1 info bytes unchanged", bad, 0);
            chk(lat_err == 0, "R1 one-cycle forward", lat_err, 0);
            bad = 0;
            root = 8'h01;
            for (int j = 0; j < 16; j++) begin
                s = 8'h00;
                for (int n = 0; n < NTOT; n++) s = fmul(s, root) ^ rec[n];
                if (s != 8'h00) bad++;
                root = fmul(root, 8'h02);
            end
            chk(bad == 0, "R2 R4 nonzero syndromes", bad, 0);
            bad = 0;
            for (int n = 0; n < NTOT; n++) if (rlast[n] != (n == NTOT-1)) bad++;
            chk(bad == 0, "R6 last marker placement", bad, 0);
            chk(nrdy == 16, "R3 ready-low cycles", nrdy, 16);
            if (mode == 3) begin
                bad = 0;
                for (int n = NDATA; n < NTOT; n++) if (rec[n] != 8'h00) bad++;
                chk(bad == 0, "R8 zero parity", bad, 0);
            end
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rcnt = 0; lat_err = 0; nrdy = 0;
        rst = 1'b1;
        tick(); tick();
        // R7 reset state
        chk(!out_valid, "R7 out_valid in reset", int'(out_valid), 0);
        chk(!out_last, "R7 out_last in reset", int'(out_last), 0);
        chk(in_ready, "R7 in_ready in reset", int'(in_ready), 1);
        rst = 1'b0;

        foreach (STIM[i]) begin
            send(STIM[i], NDATA, 20, 1'b1);
        end

        // R5: abandon a partial codeword, restart with in_start
        send(32'h0000_0099, 50, 0, 1'b0);
        send(32'h0000_0ABC, NDATA, 20, 1'b1);
        chk(1'b1, "R5 restart verified above", 0, 0);

        // R7: reset in the middle of the drain phase
        send(32'h0100_0777, NDATA, 5, 1'b0);
        rst = 1'b1;
        tick();
        chk(!out_valid, "R7 out_valid after mid-drain reset", int'(out_valid), 0);
        chk(in_ready, "R7 in_ready after mid-drain reset", int'(in_ready), 1);
        chk(!out_last, "R7 out_last after mid-drain reset", int'(out_last), 0);
        rst = 1'b0;
        tick();
        send(32'h0200_2222, NDATA, 20, 1'b1);

        // R4: idle stretch with no start keeps block quiet
        rcnt = 0;
        for (int k = 0; k < 10; k++) tick();
        chk(rcnt == 0, "R4 no output while idle", rcnt, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule